// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 15-bit program counter of a small microcontroller and works out the value it takes next. Each instruction is described to the block by a class code and by the fields the class needs. Those fields are the instruction length in bytes, a full 15-bit target, a 12-bit in-page target, a 6-bit signed displacement, the accumulator and the address popped from the return stack. From these the block forms one of several targets:

- a plain advance past the instruction;
- a full 15-bit load;
- a 12-bit load that keeps the top three bits (a 4K page);
- a short relative hop over the full 15 bits;
- an accumulator-indexed load that keeps the top seven bits;
- a return.

The counter only moves on an instruction-cycle strobe. The block makes this strobe itself, once every ten input clocks. Alongside the counter it reports whether the current fetch address lies beyond the implemented program memory, and it presents that address. The fetch path uses this flag to substitute the zero trap opcode. Decode, the stack RAM and the skip decision belong to other blocks.

Top module: `pcu_next_addr`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `pc` is 0, `trap_flag` is 0, `trap_addr` is 0 and `cyc_en` is 0.
- R2: `cyc_en` is high for exactly one clock in every ten, first in the tenth clock after reset is released. `pc`, `trap_flag` and `trap_addr` change only on the clock edge where `cyc_en` is high.
- R3: Class codes are SEQ=0, LONG=1, PAGE=2, REL=3, IND=4, RET=5; codes 6 and 7 act as SEQ. SEQ loads `pc + ilen`, where `ilen` is 1 to 3.
- R4: LONG loads `imm_long` (all 15 bits).
- R5: PAGE loads bits [14:12] of `pc + ilen` joined with `imm_page` as bits [11:0]. A page carry caused by the advance is therefore kept.
- R6: REL loads `pc + ilen + sext(rel_off)`, with `rel_off` a 6-bit two's-complement value (-32..+31), added over all 15 bits.
- R7: REL with `rel_off` = 0 is not a valid displacement and behaves as SEQ.
- R8: IND loads bits [14:8] of `pc + ilen` joined with `acc` as bits [7:0].
- R9: RET loads `ret_addr`.
- R10: Every addition wraps modulo 2^15, so 0x7FFF + 1 gives 0 and 0 - 32 + 1 gives 0x7FE1.
- R11: `trap_flag` is 1 exactly when `pc` is at or above `MEM_BYTES` (default 8192). `trap_addr` equals `pc` while `trap_flag` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| kind | input | 3 | Instruction class code |
| ilen | input | 2 | Instruction length in bytes (1..3) |
| imm_long | input | 15 | Full target for LONG |
| imm_page | input | 12 | In-page target for PAGE |
| rel_off | input | 6 | Signed displacement for REL |
| acc | input | 8 | Accumulator, low byte of the IND target |
| ret_addr | input | 15 | Address popped from the return stack |
| cyc_en | output | 1 | Instruction-cycle strobe |
| pc | output | 15 | Program counter |
| trap_flag | output | 1 | Fetch address is beyond implemented memory |
| trap_addr | output | 15 | Out-of-range fetch address, else 0 |

## Verification
The bench sets up a paged jump from 0x0FFF with a two-byte length. A design that paged on the old counter rather than the advanced one would land in page 0 instead of page 1. Relative hops of +31 and -32 are taken near address zero and at the top of memory. These expose a sign-extension slip or a carry dropped at bit 14, which would send the counter into the wrong half of the space. A zero displacement checks that the invalid encoding advances rather than stalls. Long jumps and returns step the counter across `MEM_BYTES`, so a flag registered one cycle late, or computed from the old counter, shows at once. A strobe off by one clock shows as early updates.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    BR_SEQ  = 3'd0,
    BR_LONG = 3'd1,
    BR_PAGE = 3'd2,
    BR_REL  = 3'd3,
    BR_IND  = 3'd4,
    BR_RET  = 3'd5
  } br_kind_e;
endpackage

// File: rtl/pcu_cycle_tick.sv
module pcu_cycle_tick #(
  parameter int CYC_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST) && !rst;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int PC_W   = 15,
  parameter int PAGE_W = 12,
  parameter int IND_W  = 8,
  parameter int REL_W  = 6
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [2:0]        kind,
  input  logic [1:0]        ilen,
  input  logic [PC_W-1:0]   imm_long,
  input  logic [PAGE_W-1:0] imm_page,
  input  logic [REL_W-1:0]  rel_off,
  input  logic [IND_W-1:0]  acc,
  input  logic [PC_W-1:0]   ret_addr,
  output logic [PC_W-1:0]   nxt
);
  logic [PC_W-1:0] seq;
  logic [PC_W-1:0] rel_ext;
  logic [PC_W-1:0] page_tgt;
  logic [PC_W-1:0] ind_tgt;

  assign seq     = pc + {{(PC_W-2){1'b0}}, ilen};
  assign rel_ext = {{(PC_W-REL_W){rel_off[REL_W-1]}}, rel_off};

  generate
    if (PAGE_W < PC_W) begin : g_page
      assign page_tgt = {seq[PC_W-1:PAGE_W], imm_page};
    end else begin : g_page_full
      assign page_tgt = imm_page[PC_W-1:0];
    end
    if (IND_W < PC_W) begin : g_ind
      assign ind_tgt = {seq[PC_W-1:IND_W], acc};
    end else begin : g_ind_full
      assign ind_tgt = acc[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (br_kind_e'(kind))
      BR_LONG: nxt = imm_long;
      BR_PAGE: nxt = page_tgt;
      BR_REL:  nxt = (rel_off == '0) ? seq : seq + rel_ext;
      BR_IND:  nxt = ind_tgt;
      BR_RET:  nxt = ret_addr;
      default: nxt = seq;
    endcase
  end
endmodule

// File: rtl/pcu_fetch_guard.sv
module pcu_fetch_guard #(
  parameter int PC_W      = 15,
  parameter int MEM_BYTES = 8192
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [PC_W-1:0] nxt,
  output logic            trap_flag,
  output logic [PC_W-1:0] trap_addr
);
  localparam logic [PC_W:0] LIMIT = (PC_W+1)'(MEM_BYTES);

  logic oor;
  assign oor = {1'b0, nxt} >= LIMIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_flag <= 1'b0;
      trap_addr <= '0;
    end else if (load) begin
      trap_flag <= oor;
      trap_addr <= oor ? nxt : '0;
    end
  end

  // R11
  trap_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_flag |-> trap_addr == '0);
  // R11
  trap_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    trap_flag |-> {1'b0, trap_addr} >= LIMIT);
endmodule

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
  import pcu_pkg::*;
#(
  parameter int PC_W      = 15,
  parameter int PAGE_W    = 12,
  parameter int IND_W     = 8,
  parameter int REL_W     = 6,
  parameter int CYC_DIV   = 10,
  parameter int MEM_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        kind,
  input  logic [1:0]        ilen,
  input  logic [PC_W-1:0]   imm_long,
  input  logic [PAGE_W-1:0] imm_page,
  input  logic [REL_W-1:0]  rel_off,
  input  logic [IND_W-1:0]  acc,
  input  logic [PC_W-1:0]   ret_addr,
  output logic              cyc_en,
  output logic [PC_W-1:0]   pc,
  output logic              trap_flag,
  output logic [PC_W-1:0]   trap_addr
);
  logic [PC_W-1:0] nxt;

  pcu_cycle_tick #(.CYC_DIV(CYC_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (cyc_en)
  );

  pcu_target #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .IND_W(IND_W), .REL_W(REL_W)
  ) u_target (
    .pc       (pc),
    .kind     (kind),
    .ilen     (ilen),
    .imm_long (imm_long),
    .imm_page (imm_page),
    .rel_off  (rel_off),
    .acc      (acc),
    .ret_addr (ret_addr),
    .nxt      (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else if (cyc_en) pc <= nxt;
  end

  pcu_fetch_guard #(.PC_W(PC_W), .MEM_BYTES(MEM_BYTES)) u_guard (
    .clk       (clk),
    .rst       (rst),
    .load      (cyc_en),
    .nxt       (nxt),
    .trap_flag (trap_flag),
    .trap_addr (trap_addr)
  );

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_en |=> $stable(pc));
  // R4
  long_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && kind == 3'd1) |=> pc == $past(imm_long));
  // R9
  ret_load_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && kind == 3'd5) |=> pc == $past(ret_addr));
  // R5
  page_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_en && kind == 3'd2) |=> pc[PAGE_W-1:0] == $past(imm_page));
endmodule

// File: tb/pcu_next_addr_tb.sv
module pcu_next_addr_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  kind = 3'd0;
  logic [1:0]  ilen = 2'd1;
  logic [14:0] imm_long = '0;
  logic [11:0] imm_page = '0;
  logic [5:0]  rel_off = '0;
  logic [7:0]  acc = '0;
  logic [14:0] ret_addr = '0;
  logic        cyc_en;
  logic [14:0] pc;
  logic        trap_flag;
  logic [14:0] trap_addr;

  int errors = 0;
  int checks = 0;
  int m_pc = 0;
  int m_cnt = 0;
  bit started = 0;
  bit done = 0;
  string tag = "R1 reset";

  always #4 clk = ~clk;

  pcu_next_addr u_dut (
    .clk(clk), .rst(rst), .kind(kind), .ilen(ilen), .imm_long(imm_long),
    .imm_page(imm_page), .rel_off(rel_off), .acc(acc), .ret_addr(ret_addr),
    .cyc_en(cyc_en), .pc(pc), .trap_flag(trap_flag), .trap_addr(trap_addr)
  );

  function automatic int ref_next(int cur);
    int s, off;
    s = (cur + int'(ilen)) & 32'h7FFF;
    case (kind)
      3'd1: return int'(imm_long);
      3'd2: return (s & 32'h7000) | int'(imm_page);
      3'd3: begin
        if (rel_off == 0) return s;
        off = (rel_off >= 32) ? int'(rel_off) - 64 : int'(rel_off);
        return (s + off) & 32'h7FFF;
      end
      3'd4: return (s & 32'h7F00) | int'(acc);
      3'd5: return int'(ret_addr);
      default: return s;
    endcase
  endfunction

  function automatic string kind_tag();
    case (kind)
      3'd1: return "R4 long";
      3'd2: return "R5 page";
      3'd3: return (rel_off == 0) ? "R7 rel zero" : "R6 rel";
      3'd4: return "R8 indirect";
      3'd5: return "R9 return";
      default: return "R3 sequential";
    endcase
  endfunction

  // behavioural reference, advanced at each rising edge
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_pc = 0; m_cnt = 0; tag = "R1 reset";
    end else if (m_cnt == 9) begin
      m_pc = ref_next(m_pc); m_cnt = 0; tag = kind_tag();
      if (m_pc < int'(ilen) && kind == 3'd0) tag = "R10 wrap";
    end else begin
      m_cnt = m_cnt + 1;
    end
  end

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check("R2 strobe", int'(cyc_en), (m_cnt == 9 && !rst) ? 1 : 0);
      check(tag, int'(pc), m_pc);
      check("R11 trap flag", int'(trap_flag), (m_pc >= 8192) ? 1 : 0);
      check("R11 trap addr", int'(trap_addr), (m_pc >= 8192) ? m_pc : 0);
    end
  end

  task automatic instr(int k, int len);
    kind = 3'(k); ilen = 2'(len);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R3 sequential lengths and aliases
    instr(0, 1); instr(0, 2); instr(0, 3); instr(6, 1); instr(7, 2);
    // R6 / R10 backward hop from near zero wraps to the top
    imm_long = 15'h0000; instr(1, 3);
    rel_off = 6'h20; instr(3, 1);
    rel_off = 6'h1F; instr(3, 1);
    rel_off = 6'h00; instr(3, 1);  // R7
    // R5 page carry from the advance
    imm_long = 15'h0FFF; instr(1, 3);
    imm_page = 12'hABC; instr(2, 2);
    // R8 indirect with carry into bit 8
    imm_long = 15'h12FF; instr(1, 3);
    acc = 8'h5A; instr(4, 1);
    // R11 crossing the implemented limit
    ret_addr = 15'h1FFF; instr(5, 1);
    instr(0, 1);
    imm_long = 15'h3000; instr(1, 3);
    ret_addr = 15'h0100; instr(5, 1);
    // R10 top-of-space wrap
    imm_long = 15'h7FFF; instr(1, 3);
    instr(0, 1);
    imm_long = 15'h7FF0; instr(1, 3);
    rel_off = 6'h1F; instr(3, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule